// File: doc/BRIEF.md
# ADC Input Scan and Alternate Channel Selector

This block decides, for each successive analog-to-digital conversion, which analog input drives the converter's positive path and which setting the negative path takes. Two select paths are provided, called side A and side B. Side A either holds one fixed input or walks through a set of inputs named by a 16-bit mask. Side B always holds one fixed input. When alternation is enabled, samples take side A and side B in turn, so a scanned vector of inputs can be interleaved with one reference channel.

The conversion engine pulses `advance` once for each completed conversion and pulses `restart` at the start of a new conversion sequence. The channel outputs are combinational from the configuration inputs and two pieces of state: a scan pointer and an alternation phase. The analog multiplexer itself sits outside this block and takes `cur_pos` and `cur_neg` directly.

Top module: `adc_chan_sel`

## Requirements
- R1: While `rst_n` is low and after it is released, the scan pointer rests at input 0 and the phase is side A. A scanning side A therefore presents the lowest set mask bit.
- R2: With `scan_en` and `alt_en` both low, `cur_pos` equals `a_pos_sel`, `cur_neg` equals `a_neg_sel` and `on_mux_b` is 0, whatever `advance` does.
- R3: With `scan_en` high and a nonzero mask, a side-A sample presents an input whose mask bit is 1. Mask bit n stands for input number n.
- R4: While scanning, each `advance` on a side-A sample moves to the next set mask bit in ascending order. After the highest set bit, it wraps to the lowest set bit.
- R5: With `scan_en` high and `scan_mask` all zero, side A uses `a_pos_sel`.
- R6: With `alt_en` high, the first sample after `restart` is side A (`on_mux_b`=0). Every `advance` then flips the side, and `on_mux_b` is 1 on side B.
- R7: A side-B sample presents `b_pos_sel` and `b_neg_sel`, even while scanning is enabled.
- R8: With scanning and alternation both enabled, an `advance` on a side-B sample leaves the scan position unchanged. The scanned inputs and the side-B input therefore interleave one for one.
- R9: `restart` sets the scan position back to the lowest set mask bit and the phase back to side A. It wins over a simultaneous `advance`.
- R10: A side-A sample always presents `a_neg_sel` on `cur_neg`, whether or not scanning is enabled.
- R11: In a cycle with neither `advance` nor `restart`, the scan pointer and the phase hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| scan_en | input | 1 | Side A takes its input from the scan mask |
| alt_en | input | 1 | Alternate side A and side B on every sample |
| scan_mask | input | 16 | Bit n set puts input n in the scan |
| a_pos_sel | input | 4 | Side A fixed positive input |
| a_neg_sel | input | 1 | Side A negative select |
| b_pos_sel | input | 4 | Side B positive input |
| b_neg_sel | input | 1 | Side B negative select |
| restart | input | 1 | One-cycle pulse: begin a new sequence |
| advance | input | 1 | One-cycle pulse: a conversion finished |
| cur_pos | output | 4 | Positive input for the current sample |
| cur_neg | output | 1 | Negative select for the current sample |
| on_mux_b | output | 1 | 1 while the current sample uses side B |

## Verification
The assertions assume that `restart` and `advance` are single-cycle, synchronous events. They also assume that the configuration inputs change only between samples, so that a scan-position check always refers to the mask in force at that edge. The stimulus drives all inputs one time unit after a rising edge. It holds a random configuration for stretches of several dozen cycles before drawing a new one, and it draws zero, single-bit and dense masks, so that the wrap and fallback corners arise often. Directed sequences cover a restart that coincides with an advance, and a mask that changes while the pointer sits between set bits.

// File: rtl/adc_sel_pkg.sv
package adc_sel_pkg;
  typedef enum logic {SIDE_A = 1'b0, SIDE_B = 1'b1} side_e;
endpackage

// File: rtl/asel_scan_ptr.sv
module asel_scan_ptr #(
  parameter int NCH  = 16,
  localparam int SELW = $clog2(NCH)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            restart,
  input  logic            step,
  input  logic [NCH-1:0]  scan_mask,
  output logic [SELW-1:0] scan_ptr_o,
  output logic [SELW-1:0] scan_ch_o,
  output logic            mask_any_o
);
  // first set bit at or after 'start', searching cyclically upward
  function automatic logic [SELW-1:0] first_at_or_after(
    input logic [NCH-1:0]  mask,
    input logic [SELW-1:0] start
  );
    logic            found;
    logic [SELW-1:0] res;
    logic [SELW-1:0] idx;
    found = 1'b0;
    res   = start;
    for (int i = 0; i < NCH; i++) begin
      idx = start + SELW'(i);
      if (!found && mask[idx]) begin
        res   = idx;
        found = 1'b1;
      end
    end
    return res;
  endfunction

  logic [SELW-1:0] ptr_q;

  assign scan_ch_o  = first_at_or_after(scan_mask, ptr_q);
  assign mask_any_o = |scan_mask;
  assign scan_ptr_o = ptr_q;

  // R1 R9: pointer rests at zero after reset or restart
  always_ff @(posedge clk) begin
    if (!rst_n)       ptr_q <= '0;
    else if (restart) ptr_q <= '0;
    else if (step)    ptr_q <= scan_ch_o + SELW'(1);  // R4
  end
endmodule

// File: rtl/asel_alt_phase.sv
module asel_alt_phase (
  input  logic clk,
  input  logic rst_n,
  input  logic restart,
  input  logic advance,
  input  logic alt_en,
  output logic phase_b_o
);
  logic phase_q;
  assign phase_b_o = phase_q;

  // R6 R9: phase starts on side A and flips per conversion when alternating
  always_ff @(posedge clk) begin
    if (!rst_n)       phase_q <= 1'b0;
    else if (restart) phase_q <= 1'b0;
    else if (advance) phase_q <= alt_en ? ~phase_q : 1'b0;
  end
endmodule

// File: rtl/asel_out_mux.sv
module asel_out_mux
  import adc_sel_pkg::*;
#(
  parameter int SELW = 4
) (
  input  side_e           side,
  input  logic            use_scan,
  input  logic [SELW-1:0] scan_ch,
  input  logic [SELW-1:0] a_pos_sel,
  input  logic            a_neg_sel,
  input  logic [SELW-1:0] b_pos_sel,
  input  logic            b_neg_sel,
  output logic [SELW-1:0] pos_o,
  output logic            neg_o
);
  always_comb begin
    if (side == SIDE_B) begin
      pos_o = b_pos_sel;                          // R7
      neg_o = b_neg_sel;
    end else begin
      pos_o = use_scan ? scan_ch : a_pos_sel;     // R3 R5
      neg_o = a_neg_sel;                          // R10
    end
  end
endmodule

// File: rtl/adc_chan_sel.sv
module adc_chan_sel
  import adc_sel_pkg::*;
#(
  parameter int NCH  = 16,
  localparam int SELW = $clog2(NCH)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            scan_en,
  input  logic            alt_en,
  input  logic [NCH-1:0]  scan_mask,
  input  logic [SELW-1:0] a_pos_sel,
  input  logic            a_neg_sel,
  input  logic [SELW-1:0] b_pos_sel,
  input  logic            b_neg_sel,
  input  logic            restart,
  input  logic            advance,
  output logic [SELW-1:0] cur_pos,
  output logic            cur_neg,
  output logic            on_mux_b
);
  // named internal events for the checker
  logic            phase_b;
  logic            on_b;
  logic            scan_active;
  logic            step_scan;
  logic            mask_any;
  logic [SELW-1:0] scan_ch;
  logic [SELW-1:0] scan_ptr;
  side_e           side;

  asel_alt_phase phase_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .restart   (restart),
    .advance   (advance),
    .alt_en    (alt_en),
    .phase_b_o (phase_b)
  );

  assign on_b        = alt_en & phase_b;
  assign side        = on_b ? SIDE_B : SIDE_A;
  assign scan_active = scan_en & mask_any;
  // R8: scan position moves only on side-A samples
  assign step_scan   = advance & ~restart & scan_active & ~on_b;

  asel_scan_ptr #(.NCH(NCH)) ptr_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .restart    (restart),
    .step       (step_scan),
    .scan_mask  (scan_mask),
    .scan_ptr_o (scan_ptr),
    .scan_ch_o  (scan_ch),
    .mask_any_o (mask_any)
  );

  asel_out_mux #(.SELW(SELW)) mux_i (
    .side      (side),
    .use_scan  (scan_active),
    .scan_ch   (scan_ch),
    .a_pos_sel (a_pos_sel),
    .a_neg_sel (a_neg_sel),
    .b_pos_sel (b_pos_sel),
    .b_neg_sel (b_neg_sel),
    .pos_o     (cur_pos),
    .neg_o     (cur_neg)
  );

  assign on_mux_b = on_b;  // R2 R6
endmodule

// File: rtl/adc_chan_sel_chk.sv
module adc_chan_sel_chk #(
  parameter int NCH  = 16,
  localparam int SELW = $clog2(NCH)
) (
  input logic            clk,
  input logic            rst_n,
  input logic            scan_en,
  input logic            alt_en,
  input logic [NCH-1:0]  scan_mask,
  input logic [SELW-1:0] b_pos_sel,
  input logic            b_neg_sel,
  input logic            restart,
  input logic            advance,
  input logic [SELW-1:0] cur_pos,
  input logic            cur_neg,
  input logic            on_mux_b,
  input logic            phase_b,
  input logic [SELW-1:0] scan_ptr
);
  // R9
  restart_to_a_chk: assert property (@(posedge clk) disable iff (!rst_n)
    restart |=> !phase_b);

  // R6
  alt_toggle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (advance && !restart && alt_en) |=> (phase_b != $past(phase_b)));

  // R7
  side_b_fields_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (alt_en && phase_b) |-> (on_mux_b && cur_pos == b_pos_sel && cur_neg == b_neg_sel));

  // R3
  scan_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (scan_en && (|scan_mask) && !on_mux_b) |-> scan_mask[cur_pos]);

  // R2
  no_alt_side_a_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !alt_en |-> !on_mux_b);

  // R11
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!advance && !restart) |=> ($stable(scan_ptr) && $stable(phase_b)));

  // R8
  b_keeps_ptr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (advance && !restart && on_mux_b) |=> $stable(scan_ptr));
endmodule

bind adc_chan_sel adc_chan_sel_chk #(.NCH(NCH)) chk_i (
  .clk       (clk),
  .rst_n     (rst_n),
  .scan_en   (scan_en),
  .alt_en    (alt_en),
  .scan_mask (scan_mask),
  .b_pos_sel (b_pos_sel),
  .b_neg_sel (b_neg_sel),
  .restart   (restart),
  .advance   (advance),
  .cur_pos   (cur_pos),
  .cur_neg   (cur_neg),
  .on_mux_b  (on_mux_b),
  .phase_b   (phase_b),
  .scan_ptr  (scan_ptr)
);

// File: tb/adc_chan_sel_tb_top.sv
module adc_chan_sel_tb_top;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        scan_en, alt_en;
  logic [15:0] scan_mask;
  logic [3:0]  a_pos_sel, b_pos_sel;
  logic        a_neg_sel, b_neg_sel;
  logic        restart, advance;
  logic [3:0]  cur_pos;
  logic        cur_neg, on_mux_b;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  // bench model state
  int m_ptr = 0;
  bit m_ph  = 1'b0;

  always #5 clk = ~clk;

  adc_chan_sel dut_i (
    .clk(clk), .rst_n(rst_n), .scan_en(scan_en), .alt_en(alt_en),
    .scan_mask(scan_mask), .a_pos_sel(a_pos_sel), .a_neg_sel(a_neg_sel),
    .b_pos_sel(b_pos_sel), .b_neg_sel(b_neg_sel), .restart(restart),
    .advance(advance), .cur_pos(cur_pos), .cur_neg(cur_neg), .on_mux_b(on_mux_b)
  );

  // scanned input: rotate a doubled mask down to the start, count to first one
  function automatic int bench_scan_ch(input logic [15:0] mask, input int start);
    logic [31:0] dbl;
    int k;
    dbl = {mask, mask} >> start;
    k = 0;
    while (k < 16 && !dbl[k]) k++;
    return (start + k) % 16;
  endfunction

  function automatic bit exp_b();
    return alt_en && m_ph;
  endfunction

  function automatic int exp_pos();
    if (exp_b()) return int'(b_pos_sel);
    if (scan_en && scan_mask != 16'h0) return bench_scan_ch(scan_mask, m_ptr);
    return int'(a_pos_sel);
  endfunction

  function automatic bit exp_neg();
    return exp_b() ? b_neg_sel : a_neg_sel;
  endfunction

  function automatic string auto_tag();
    if (exp_b()) return "R7";
    if (scan_en && scan_mask != 16'h0) return "R3";
    if (scan_en) return "R5";
    return "R2";
  endfunction

  task automatic check_model(input string tag);
    checks++;
    if (int'(cur_pos) != exp_pos() || cur_neg != exp_neg() || on_mux_b != exp_b()) begin
      errors++;
      $display("FAIL %s pos/neg/b actual %0d/%0b/%0b expected %0d/%0b/%0b",
               tag, cur_pos, cur_neg, on_mux_b, exp_pos(), exp_neg(), exp_b());
    end
  endtask

  task automatic check_lit(input string tag, input int pos, input bit b);
    checks++;
    if (int'(cur_pos) != pos || on_mux_b != b) begin
      errors++;
      $display("FAIL %s pos/b actual %0d/%0b expected %0d/%0b", tag, cur_pos, on_mux_b, pos, b);
    end
  endtask

  task automatic model_update();
    if (restart) begin
      m_ptr = 0;
      m_ph  = 1'b0;
    end else if (advance) begin
      if (scan_en && scan_mask != 16'h0 && !(alt_en && m_ph))
        m_ptr = (bench_scan_ch(scan_mask, m_ptr) + 1) % 16;
      m_ph = alt_en ? ~m_ph : 1'b0;
    end
  endtask

  // inputs change 1 unit after a rising edge; check at mid-cycle
  task automatic step(input bit adv, input bit rs, input string tag);
    advance = adv;
    restart = rs;
    #4;
    check_model(tag);
    @(posedge clk);
    #1;
    model_update();
    advance = 1'b0;
    restart = 1'b0;
  endtask

  // step whose pre-edge outputs must match a literal
  task automatic step_lit(input bit adv, input string tag, input int pos, input bit b);
    advance = adv;
    restart = 1'b0;
    #4;
    check_lit(tag, pos, b);
    check_model(tag);
    @(posedge clk);
    #1;
    model_update();
    advance = 1'b0;
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      errors++;
      $display("FAIL all watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h00C0FFEE));
    rst_n = 1'b0; scan_en = 1'b0; alt_en = 1'b0; scan_mask = 16'h0;
    a_pos_sel = 4'd6; a_neg_sel = 1'b0; b_pos_sel = 4'd11; b_neg_sel = 1'b1;
    restart = 1'b0; advance = 1'b1;
    repeat (3) @(posedge clk);
    #1;
    // R1: reset state with a scanning mask, pointer at 0 -> lowest set bit 4
    scan_en = 1'b1; scan_mask = 16'h0030; advance = 1'b0;
    #4; check_lit("R1", 4, 1'b0);
    @(posedge clk); #1;
    rst_n = 1'b1;
    #4; check_lit("R1", 4, 1'b0);
    @(posedge clk); #1;

    // R2: fixed input, advance has no effect
    scan_en = 1'b0; alt_en = 1'b0; a_pos_sel = 4'd9; a_neg_sel = 1'b1;
    for (int i = 0; i < 4; i++) step_lit(1'b1, "R2", 9, 1'b0);

    // R4: ascending scan with wrap over bits 0,5,10,15
    scan_en = 1'b1; scan_mask = 16'h8421;
    step(1'b0, 1'b1, "R9");
    step_lit(1'b1, "R4", 0, 1'b0);
    step_lit(1'b1, "R4", 5, 1'b0);
    step_lit(1'b1, "R4", 10, 1'b0);
    step_lit(1'b1, "R4", 15, 1'b0);
    step_lit(1'b1, "R4", 0, 1'b0);
    // R11: no pulses, selection holds at 5
    for (int i = 0; i < 3; i++) step_lit(1'b0, "R11", 5, 1'b0);

    // R10: side A negative select follows a_neg_sel while scanning
    a_neg_sel = 1'b0; step(1'b0, 1'b0, "R10");
    a_neg_sel = 1'b1; step(1'b0, 1'b0, "R10");

    // R5: zero mask falls back to a_pos_sel
    scan_mask = 16'h0; a_pos_sel = 4'd3;
    step_lit(1'b1, "R5", 3, 1'b0);

    // R6 R8: scan bits 1,4 interleaved with side B input 7
    scan_mask = 16'h0012; alt_en = 1'b1; b_pos_sel = 4'd7;
    step(1'b0, 1'b1, "R9");
    step_lit(1'b1, "R6", 1, 1'b0);
    step_lit(1'b1, "R8", 7, 1'b1);
    step_lit(1'b1, "R8", 4, 1'b0);
    step_lit(1'b1, "R6", 7, 1'b1);
    step_lit(1'b1, "R8", 1, 1'b0);

    // R9: restart together with advance wins; lands on side A, lowest bit
    step(1'b1, 1'b0, "R6");
    step(1'b1, 1'b1, "R9");
    step_lit(1'b0, "R9", 1, 1'b0);

    // mask changed while pointer sits between set bits
    scan_mask = 16'h0012;
    step(1'b1, 1'b0, "R3");
    scan_mask = 16'h4001;
    step(1'b0, 1'b0, "R3");

    // random mix
    for (int n = 0; n < 4000; n++) begin
      if ($urandom_range(0, 47) == 0) begin
        scan_en = 1'($urandom_range(0, 1));
        alt_en  = 1'($urandom_range(0, 1));
        case ($urandom_range(0, 3))
          0: scan_mask = 16'h0;
          1: scan_mask = 16'h1 << $urandom_range(0, 15);
          default: scan_mask = 16'($urandom);
        endcase
        a_pos_sel = 4'($urandom); b_pos_sel = 4'($urandom);
        a_neg_sel = 1'($urandom); b_neg_sel = 1'($urandom);
      end
      step(1'($urandom_range(0, 1)), ($urandom_range(0, 15) == 0), auto_tag());
    end

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule